// File: doc/BRIEF.md
# Logarithmic Digital Volume Stage for PCM Samples

This block scales a stream of signed 24-bit audio samples by a gain chosen through an 8-bit logarithmic code. Each code step is 0.375 dB. Code 192 is unity gain, code 255 is the loudest setting (+23.625 dB) and code 1 is the quietest (-71.625 dB). Code 0 is reserved and silences the output. The block sits between a recording filter chain and whatever consumes its samples. One valid-qualified sample goes in, and the same sample, scaled, comes out a fixed two cycles later.

The volume code is double-buffered. A write always lands in a pending register. The gain in use changes only when the write carries its update flag, or when a separate commit strobe copies the pending code across. A channel mute bit and a global mute bit are both writable. When either is set, or when the channel enable input is low, every sample leaves as exact zero and the valid pulses keep their original spacing. Each sample carries the gain, mute and enable state that held when it was accepted. A control change therefore never splits a sample in flight.

Top module: `pcm_volume`

## Requirements
- R1: After reset, out_valid and out_sample are 0, both mute bits are clear, and both the pending and active codes are 192, so the first sample passes through unchanged.
- R2: For a nonzero active code c, let d = c - 192, s = d >>> 4 (arithmetic) and k = d mod 16. The output is floor(x * F[k] * 2^s / 2^15), where F[k] = floor(32768 * 2^(k/16)). Code 192 therefore returns the input exactly.
- R3: The scaled result saturates to the range -8388608 to 8388607. A nonnegative input never produces a negative output.
- R4: Active code 0 makes every output sample 0.
- R5: A volume write (vol_wr) with vol_upd = 0 changes only the pending code. Samples accepted afterwards keep the previous gain.
- R6: A volume write with vol_upd = 1 makes the written code active at that clock edge. A vol_commit strobe without such a write makes the pending code, as held before that edge, active. The new gain applies to samples accepted at later edges.
- R7: When mute_ch or mute_all (loaded together by mute_wr) is set, every output sample is 0.
- R8: While chan_en is 0, every output sample is 0, and out_valid still follows in_valid.
- R9: out_valid equals in_valid delayed by exactly two clock cycles.
- R10: Gain, mute and enable are captured with the sample. A control change in the cycle after a sample is accepted does not alter that sample's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; low forces zero output |
| vol_wr | input | 1 | Volume register write strobe |
| vol_code | input | 8 | Volume code carried by the write |
| vol_upd | input | 1 | Update flag carried by the write |
| vol_commit | input | 1 | Copy pending code to active code |
| mute_wr | input | 1 | Mute register write strobe |
| mute_ch_d | input | 1 | Channel mute value for mute_wr |
| mute_all_d | input | 1 | Global mute value for mute_wr |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 24 | Signed scaled output sample |

## Verification
A wrong active or pending code shows up as a wrong magnitude on the first valid output after the sample that used it, two cycles after acceptance. A lost commit or a leaked non-update write therefore appears within one sample. A stuck mute or enable path appears as a zero where a scaled value is expected, or the reverse, in that same two-cycle window. A table entry or shift error shows only for codes whose low four bits or upper bits select it. Random codes are therefore spread over the whole range, with saturating extremes driven directly.

// File: rtl/pcm_volume_pkg.sv
// Shared constants for the PCM volume stage.
// Assumes the code step is 1/16 of a factor of two (16 x 0.375 dB = 6 dB).
package pcm_volume_pkg;
    localparam int SAMPLE_W   = 24;   // audio sample width
    localparam int CODE_W     = 8;    // volume code width
    localparam int UNITY_CODE = 192;  // code giving 0 dB
    localparam int STEP_LG2   = 4;    // 16 codes per octave
    localparam int FRAC_W     = 15;   // fraction bits of the multiplier (Q1.15)
    localparam int MULT_W     = FRAC_W + 1;
    localparam int SH_W       = CODE_W + 1 - STEP_LG2;
endpackage

// File: rtl/pcm_volume_regs.sv
// Volume and mute control registers.
// Holds the pending and active volume codes and both mute bits.
// Assumes vol_wr with vol_upd takes priority over vol_commit in the same cycle.
module pcm_volume_regs
    import pcm_volume_pkg::*;
#(
    parameter int CW    = CODE_W,
    parameter int UNITY = UNITY_CODE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vol_wr,
    input  logic [CW-1:0] vol_code,
    input  logic          vol_upd,
    input  logic          vol_commit,
    input  logic          mute_wr,
    input  logic          mute_ch_d,
    input  logic          mute_all_d,
    output logic [CW-1:0] active_code,
    output logic          mute_ch_q,
    output logic          mute_all_q
);
    localparam logic [CW-1:0] RESET_CODE = CW'(UNITY);

    logic [CW-1:0] pend_code;

    // Purpose: capture written codes and move pending to active on an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_code   <= RESET_CODE;
            active_code <= RESET_CODE;
        end else begin
            if (vol_wr) begin
                pend_code <= vol_code;
            end
            if (vol_wr && vol_upd) begin
                active_code <= vol_code;
            end else if (vol_commit) begin
                active_code <= pend_code;
            end
        end
    end

    // Purpose: hold the channel and global mute bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_ch_q  <= 1'b0;
            mute_all_q <= 1'b0;
        end else if (mute_wr) begin
            mute_ch_q  <= mute_ch_d;
            mute_all_q <= mute_all_d;
        end
    end

    a_r5_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        (vol_wr && !vol_upd && !vol_commit) |=> $stable(active_code));

    a_r6_update_loads_code: assert property (@(posedge clk) disable iff (!rst_n)
        (vol_wr && vol_upd) |=> (active_code == $past(vol_code)));

    a_r6_commit_loads_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (vol_commit && !(vol_wr && vol_upd)) |=> (active_code == $past(pend_code)));
endmodule

// File: rtl/pcm_volume_gain_map.sv
// Converts a logarithmic volume code into a fractional multiplier and a right shift.
// The code offset from unity splits into octaves (upper bits) and 1/16-octave steps (low bits).
// Assumes STEP_LG2 == 4: the fraction table has 16 entries, floor(32768 * 2^(k/16)).
module pcm_volume_gain_map
    import pcm_volume_pkg::*;
#(
    parameter int CW    = CODE_W,
    parameter int UNITY = UNITY_CODE,
    parameter int FW    = FRAC_W,
    parameter int LG    = STEP_LG2
) (
    input  logic [CW-1:0]      code,
    output logic [FW:0]        mult,
    output logic [CW-LG:0]     rsh,
    output logic               is_mute_code
);
    localparam logic signed [CW:0] UNITY_S = (CW+1)'(UNITY);

    logic signed [CW:0] diff;
    logic [LG-1:0]      step;

    // Purpose: signed distance from the unity code.
    always_comb begin
        diff = $signed({1'b0, code}) - UNITY_S;
        step = diff[LG-1:0];
    end

    // Purpose: total right shift = fraction bits minus the octave count.
    always_comb begin
        rsh = (CW-LG+1)'(FW) - diff[CW:LG];
    end

    // Purpose: fractional multiplier 2^(step/16) in unsigned Q1.15.
    always_comb begin
        case (step)
            4'd0:    mult = 16'd32768;
            4'd1:    mult = 16'd34218;
            4'd2:    mult = 16'd35733;
            4'd3:    mult = 16'd37315;
            4'd4:    mult = 16'd38967;
            4'd5:    mult = 16'd40693;
            4'd6:    mult = 16'd42494;
            4'd7:    mult = 16'd44376;
            4'd8:    mult = 16'd46340;
            4'd9:    mult = 16'd48392;
            4'd10:   mult = 16'd50535;
            4'd11:   mult = 16'd52772;
            4'd12:   mult = 16'd55108;
            4'd13:   mult = 16'd57548;
            4'd14:   mult = 16'd60096;
            default: mult = 16'd62757;
        endcase
    end

    // Purpose: flag the reserved silence code.
    always_comb begin
        is_mute_code = (code == '0);
    end
endmodule

// File: rtl/pcm_volume_path.sv
// Two-stage sample path: stage 1 captures the sample with its gain and zero request,
// stage 2 multiplies, shifts, saturates and drives the output.
// Assumes the shift amount lies within the product width.
module pcm_volume_path
    import pcm_volume_pkg::*;
#(
    parameter int W  = SAMPLE_W,
    parameter int FW = FRAC_W,
    parameter int SW = SH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_sample,
    input  logic [FW:0]         mult,
    input  logic [SW-1:0]       rsh,
    input  logic                force_zero,
    output logic                out_valid,
    output logic signed [W-1:0] out_sample
);
    localparam int PROD_W = W + FW + 2;

    logic                     s1_valid;
    logic signed [W-1:0]      s1_sample;
    logic [FW:0]              s1_mult;
    logic [SW-1:0]            s1_rsh;
    logic                     s1_zero;

    logic signed [PROD_W-1:0] samp_ext;
    logic signed [PROD_W-1:0] mult_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [W-1:0]      sat_val;
    logic                     ovf;

    // Purpose: stage 1, capture the sample together with the gain in force at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_sample <= '0;
            s1_mult   <= '0;
            s1_rsh    <= '0;
            s1_zero   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_sample <= in_sample;
                s1_mult   <= mult;
                s1_rsh    <= rsh;
                s1_zero   <= force_zero;
            end
        end
    end

    // Purpose: full-precision product followed by an arithmetic right shift.
    always_comb begin
        samp_ext = {{(PROD_W-W){s1_sample[W-1]}}, s1_sample};
        mult_ext = {{(PROD_W-FW-1){1'b0}}, s1_mult};
        prod     = samp_ext * mult_ext;
        shifted  = prod >>> s1_rsh;
    end

    // Purpose: clamp to the signed sample range when the upper bits disagree.
    always_comb begin
        ovf = (shifted[PROD_W-1:W-1] != '0) && (shifted[PROD_W-1:W-1] != '1);
        if (ovf) begin
            sat_val = shifted[PROD_W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            sat_val = shifted[W-1:0];
        end
    end

    // Purpose: stage 2, register the result or zero when muted or disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_sample <= s1_zero ? '0 : sat_val;
            end
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_zero && !s1_sample[W-1]) |=> !out_sample[W-1]);

    a_r8_zero_when_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_zero) |=> (out_sample == '0));
endmodule

// File: rtl/pcm_volume.sv
// Top of the PCM volume stage: control registers, code-to-gain map and sample path.
// Assumes control writes and samples share one clock; the state at a sample's
// accepting edge (before that edge's writes) applies to the sample.
module pcm_volume
    import pcm_volume_pkg::*;
#(
    parameter int W  = SAMPLE_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          vol_wr,
    input  logic [CW-1:0] vol_code,
    input  logic          vol_upd,
    input  logic          vol_commit,
    input  logic          mute_wr,
    input  logic          mute_ch_d,
    input  logic          mute_all_d,
    input  logic          in_valid,
    input  logic [W-1:0]  in_sample,
    output logic          out_valid,
    output logic [W-1:0]  out_sample
);
    localparam int SW = CW + 1 - STEP_LG2;

    logic [CW-1:0]       active_code;
    logic                mute_ch_q;
    logic                mute_all_q;
    logic [FRAC_W:0]     mult;
    logic [SW-1:0]       rsh;
    logic                is_mute_code;
    logic                force_zero;
    logic signed [W-1:0] path_out;

    pcm_volume_regs #(.CW(CW), .UNITY(UNITY_CODE)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .vol_wr      (vol_wr),
        .vol_code    (vol_code),
        .vol_upd     (vol_upd),
        .vol_commit  (vol_commit),
        .mute_wr     (mute_wr),
        .mute_ch_d   (mute_ch_d),
        .mute_all_d  (mute_all_d),
        .active_code (active_code),
        .mute_ch_q   (mute_ch_q),
        .mute_all_q  (mute_all_q)
    );

    pcm_volume_gain_map #(.CW(CW), .UNITY(UNITY_CODE), .FW(FRAC_W), .LG(STEP_LG2)) u_map (
        .code         (active_code),
        .mult         (mult),
        .rsh          (rsh),
        .is_mute_code (is_mute_code)
    );

    // Purpose: any of the four silence conditions zeroes the sample.
    always_comb begin
        force_zero = !chan_en || mute_ch_q || mute_all_q || is_mute_code;
    end

    pcm_volume_path #(.W(W), .FW(FRAC_W), .SW(SW)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  ($signed(in_sample)),
        .mult       (mult),
        .rsh        (rsh),
        .force_zero (force_zero),
        .out_valid  (out_valid),
        .out_sample (path_out)
    );

    assign out_sample = path_out;

    a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    a_r7_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mute_ch_q || mute_all_q)) |-> ##2 (out_sample == '0));

    a_r4_code_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && active_code == '0) |-> ##2 (out_sample == '0));
endmodule

// File: tb/pcm_volume_bench.sv
module pcm_volume_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        chan_en;
    logic        vol_wr;
    logic [7:0]  vol_code;
    logic        vol_upd;
    logic        vol_commit;
    logic        mute_wr;
    logic        mute_ch_d;
    logic        mute_all_d;
    logic        in_valid;
    logic [23:0] in_sample;
    logic        out_valid;
    logic [23:0] out_sample;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // bench model of the control state
    int m_pend, m_active;
    bit m_mch, m_mall;

    // expectation of the previous cycle's input
    bit    prev_v;
    int    prev_val;
    string prev_tag;
    string cur_tag = "";

    always #5 clk = ~clk;

    pcm_volume u_pcm_volume (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .vol_wr(vol_wr), .vol_code(vol_code), .vol_upd(vol_upd), .vol_commit(vol_commit),
        .mute_wr(mute_wr), .mute_ch_d(mute_ch_d), .mute_all_d(mute_all_d),
        .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic longint frac_of(int k);
        return longint'($floor($pow(2.0, real'(k) / 16.0) * 32768.0));
    endfunction

    function automatic int gain_ref(int code, int smp);
        int d = code - 192;
        int s = d >>> 4;
        int k = d & 15;
        longint p = longint'(smp) * frac_of(k);
        p = p >>> (15 - s);
        if (p > 64'sd8388607) p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return int'(p);
    endfunction

    task automatic check_int(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_cycle(input bit v, input int smp);
        bit    e_v = v;
        int    e_val = 0;
        string e_tag = "R2";
        int    old_p;
        in_valid  = v;
        in_sample = smp[23:0];
        if (v) begin
            if (!chan_en) begin e_val = 0; e_tag = "R8"; end
            else if (m_mch || m_mall) begin e_val = 0; e_tag = "R7"; end
            else if (m_active == 0) begin e_val = 0; e_tag = "R4"; end
            else begin
                e_val = gain_ref(m_active, smp);
                if (e_val == 8388607 || e_val == -8388608) e_tag = "R3";
            end
            if (cur_tag != "") e_tag = cur_tag;
        end
        old_p = m_pend;
        if (vol_wr) m_pend = int'(vol_code);
        if (vol_wr && vol_upd) m_active = int'(vol_code);
        else if (vol_commit) m_active = old_p;
        if (mute_wr) begin m_mch = mute_ch_d; m_mall = mute_all_d; end
        @(negedge clk);
        check_int("R9", "out_valid", int'(out_valid), int'(prev_v));
        if (prev_v) check_int(prev_tag, "out_sample", $signed(out_sample), prev_val);
        prev_v = e_v; prev_val = e_val; prev_tag = e_tag;
        vol_wr = 0; vol_upd = 0; vol_commit = 0; mute_wr = 0;
    endtask

    task automatic set_vol(int code, bit upd);
        vol_wr = 1; vol_code = code[7:0]; vol_upd = upd;
        run_cycle(0, 0);
    endtask

    task automatic set_mute(bit ch, bit all);
        mute_wr = 1; mute_ch_d = ch; mute_all_d = all;
        run_cycle(0, 0);
    endtask

    task automatic flush();
        run_cycle(0, 0);
        run_cycle(0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r;
        rst_n = 0; chan_en = 1; vol_wr = 0; vol_code = 0; vol_upd = 0; vol_commit = 0;
        mute_wr = 0; mute_ch_d = 0; mute_all_d = 0; in_valid = 0; in_sample = 0;
        m_pend = 192; m_active = 192; m_mch = 0; m_mall = 0;
        prev_v = 0; prev_val = 0; prev_tag = "R9";
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        check_int("R1", "out_valid after reset", int'(out_valid), 0);
        check_int("R1", "out_sample after reset", int'(out_sample), 0);
        cur_tag = "R1";
        run_cycle(1, 1234567);
        run_cycle(1, -77);
        cur_tag = "";
        flush();

        // R2: unity and +/- one octave
        run_cycle(1, -8388608);
        set_vol(208, 1);
        run_cycle(1, 1000);
        set_vol(176, 1);
        run_cycle(1, -1001);
        set_vol(1, 1);
        run_cycle(1, 8388607);
        // R3: saturation at maximum gain
        set_vol(255, 1);
        run_cycle(1, 8388607);
        run_cycle(1, -8388608);
        run_cycle(1, 2000000);
        run_cycle(1, 100);
        // R4: reserved code
        set_vol(0, 1);
        run_cycle(1, 555555);
        // R5: write without update keeps the gain
        set_vol(192, 1);
        cur_tag = "R5";
        set_vol(208, 0);
        run_cycle(1, 1000);
        // R6: commit and update paths
        cur_tag = "R6";
        vol_commit = 1;
        run_cycle(1, 1000);
        run_cycle(1, 1000);
        set_vol(176, 0);
        vol_wr = 1; vol_code = 8'd224; vol_upd = 1; vol_commit = 1;
        run_cycle(0, 0);
        run_cycle(1, 4000);
        // R10: change right after acceptance
        cur_tag = "R10";
        run_cycle(1, 3000);
        vol_wr = 1; vol_code = 8'd192; vol_upd = 1; mute_wr = 1; mute_ch_d = 1; mute_all_d = 0;
        run_cycle(0, 0);
        run_cycle(1, 3000);
        cur_tag = "";
        // R7: each mute bit alone
        set_mute(0, 1);
        run_cycle(1, 4242);
        set_mute(0, 0);
        run_cycle(1, 4242);
        // R8: disable keeps valid spacing
        chan_en = 0;
        run_cycle(1, 999);
        run_cycle(0, 0);
        run_cycle(1, -999);
        chan_en = 1;
        run_cycle(1, 999);
        flush();

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            int smp;
            r = $urandom_range(0, 99);
            if (r < 3) begin
                vol_wr = 1;
                case ($urandom_range(0, 4))
                    0: vol_code = 8'd0;
                    1: vol_code = 8'd255;
                    2: vol_code = 8'd1;
                    default: vol_code = 8'($urandom_range(0, 255));
                endcase
                vol_upd = $urandom_range(0, 1) == 1;
            end
            if ($urandom_range(0, 59) == 0) vol_commit = 1;
            if ($urandom_range(0, 99) == 0) begin
                mute_wr = 1;
                mute_ch_d = $urandom_range(0, 3) == 0;
                mute_all_d = $urandom_range(0, 3) == 0;
            end
            if ($urandom_range(0, 199) == 0) chan_en = ~chan_en;
            case ($urandom_range(0, 5))
                0: smp = 8388607;
                1: smp = -8388608;
                2: smp = $urandom_range(0, 2000) - 1000;
                default: smp = int'($signed(24'($urandom())));
            endcase
            run_cycle($urandom_range(0, 9) < 7, smp);
        end
        flush();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule